// File: doc/BRIEF.md
# NAND Page Program Rule Checker

This block is a command front-end for a flash-style page array. It takes one command at a time: a page read, a page program or a block erase. Each command is addressed by a block index and a page index. Before a command may change the stored pages, the block applies the rules of flash media. Pages inside a block must be programmed in rising order. One page may take only a limited number of partial programs before its block is erased. A program can only clear bits: the stored word becomes the old value ANDed with the new data. Every page carries a small spare field next to its main data. The spare field is programmed, erased and read together with the page.

A command that breaks a rule is answered with an error code and leaves the array untouched. The page array is a set of flops inside the block. The page and spare widths, the block and page counts and the partial-program limit are all parameters. The limit is set to 4 for single-level media and to 1 for multi-level media.

Commands and responses are valid/ready streams. A command is accepted when `cmd_valid` and `cmd_ready` are both high. Exactly one response follows for each command. `cmd_ready` is high whenever no response is waiting, or whenever the waiting response is being taken in that same cycle. If the consumer holds `rsp_ready` low, a pending response stalls the command side. It does not drop anything.

Top module: `nand_prog_guard`

## Requirements
- R1: After reset `rsp_valid` is 0, `cmd_ready` is 1, every page and spare field reads as all ones, every block's write position is page 0 and every partial-program count is 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. Its response is valid after that same edge. `cmd_ready` equals `!rsp_valid || rsp_ready`, so a held response and a new command can be exchanged on one edge, and back-to-back commands are accepted on consecutive cycles.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_err`, `rsp_data` and `rsp_spare` hold their values.
- R4: A read (`cmd_op` 0) of an in-range page returns error code 0, the page contents on `rsp_data` and its spare field on `rsp_spare`.
- R5: A program (`cmd_op` 1) to the block's current write position succeeds with code 0. It ANDs `cmd_data` and `cmd_spare` into the stored page and spare, sets that page's count to 1 and advances the write position by one.
- R6: A program to a page above the block's write position is rejected with code 1 (order), and nothing changes.
- R7: A program to a page below the write position is a partial program. It succeeds, ANDing its data in and raising the page count by one, while the count is below `NOP_MAX`. Otherwise it is rejected with code 2 (count exceeded) and nothing changes.
- R8: Opcode 3, a block index of `BLOCKS` or more, or (for reads and programs) a page index of `PAGES` or more is rejected with code 3 (range), and nothing changes. An erase ignores the page index.
- R9: An erase (`cmd_op` 2) of an in-range block succeeds with code 0. It sets every page and spare of that block to all ones, and sets the block's write position and all its page counts to 0. Other blocks are untouched.
- R10: `rsp_data` and `rsp_spare` are 0 for every rejected command and for every program or erase response. Only a successful read carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| cmd_blk | input | $clog2(BLOCKS) | Block index |
| cmd_page | input | $clog2(PAGES) | Page index within the block |
| cmd_data | input | PAGE_BYTES*8 | Program data, main area |
| cmd_spare | input | SPARE_BYTES*8 | Program data, spare field |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_err | output | 2 | 0 ok, 1 order, 2 count exceeded, 3 range |
| rsp_data | output | PAGE_BYTES*8 | Read data, main area |
| rsp_spare | output | SPARE_BYTES*8 | Read data, spare field |

## Verification
The two functions that meet in one cycle are handing over a pending response and accepting the next command. Both happen on the edge where `rsp_ready` rises under a waiting response while `cmd_valid` is high. The bench provokes this in two ways. It keeps commands always valid while a pseudo-random pattern drives `rsp_ready`. It also streams commands back to back with `rsp_ready` held high. A behavioural model in the bench predicts `cmd_ready`, `rsp_valid` and the response contents on every cycle. This exposes any lost, duplicated or overwritten response, and any command that slips in while the output is stalled.

// File: rtl/npg_pkg.sv
package npg_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ORDER = 2'd1,
    ERR_NOP   = 2'd2,
    ERR_RANGE = 2'd3
  } err_e;

endpackage

// File: rtl/npg_rules.sv
module npg_rules
  import npg_pkg::*;
#(
  parameter int BLOCKS  = 6,
  parameter int PAGES   = 6,
  parameter int NOP_MAX = 4,
  parameter int BLK_W   = 3,
  parameter int PG_W    = 3,
  parameter int PTR_W   = 3,
  parameter int CNT_W   = 3
) (
  input  op_e              op,
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  page,
  input  logic [PTR_W-1:0] nxt,
  input  logic [CNT_W-1:0] cnt,
  output err_e             err
);

  logic blk_bad;
  logic page_bad;

  assign blk_bad  = int'(blk) >= BLOCKS;
  assign page_bad = (op != OP_ERASE) && (int'(page) >= PAGES);

  // range first, then order, then the partial-program limit
  always_comb begin
    err = ERR_NONE;
    if (op == OP_BAD || blk_bad || page_bad) begin
      err = ERR_RANGE;
    end else if (op == OP_PROG) begin
      if (int'(page) > int'(nxt)) begin
        err = ERR_ORDER;
      end else if (int'(page) < int'(nxt) && int'(cnt) >= NOP_MAX) begin
        err = ERR_NOP;
      end
    end
  end

endmodule

// File: rtl/npg_book.sv
module npg_book #(
  parameter int BLOCKS = 6,
  parameter int PAGES  = 6,
  parameter int BLK_W  = 3,
  parameter int PG_W   = 3,
  parameter int PTR_W  = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  page,
  input  logic             prog_en,
  input  logic             erase_en,
  output logic [PTR_W-1:0] nxt,
  output logic [CNT_W-1:0] cnt
);

  logic [BLOCKS*PTR_W-1:0]       ptr_flat;
  logic [BLOCKS*PAGES*CNT_W-1:0] cnt_flat;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    logic             blk_hit;
    logic [PTR_W-1:0] ptr_q;

    assign blk_hit = (blk == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (erase_en && blk_hit) begin
        ptr_q <= '0;
      end else if (prog_en && blk_hit && ptr_q == PTR_W'(page)) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
    assign ptr_flat[b*PTR_W +: PTR_W] = ptr_q;

    for (genvar p = 0; p < PAGES; p++) begin : g_pg
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (erase_en && blk_hit) begin
          cnt_q <= '0;
        end else if (prog_en && blk_hit && page == PG_W'(p)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign cnt_flat[(b*PAGES+p)*CNT_W +: CNT_W] = cnt_q;
    end
  end

  int bsel;
  int psel;

  always_comb begin
    bsel = (int'(blk) < BLOCKS) ? int'(blk) : 0;
    psel = (int'(page) < PAGES) ? int'(page) : 0;
    nxt  = ptr_flat[bsel*PTR_W +: PTR_W];
    cnt  = cnt_flat[(bsel*PAGES+psel)*CNT_W +: CNT_W];
  end

endmodule

// File: rtl/npg_array.sv
module npg_array #(
  parameter int BLOCKS = 6,
  parameter int PAGES  = 6,
  parameter int BLK_W  = 3,
  parameter int PG_W   = 3,
  parameter int W      = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  page,
  input  logic             prog_en,
  input  logic             erase_en,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);

  logic [BLOCKS*PAGES*W-1:0] cells;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    logic blk_hit;
    assign blk_hit = (blk == BLK_W'(b));

    for (genvar p = 0; p < PAGES; p++) begin : g_pg
      logic [W-1:0] cell_q;

      // erased flash reads as ones; a program can only clear bits
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q <= '1;
        end else if (erase_en && blk_hit) begin
          cell_q <= '1;
        end else if (prog_en && blk_hit && page == PG_W'(p)) begin
          cell_q <= cell_q & wdata;
        end
      end
      assign cells[(b*PAGES+p)*W +: W] = cell_q;
    end
  end

  int bsel;
  int psel;

  always_comb begin
    bsel  = (int'(blk) < BLOCKS) ? int'(blk) : 0;
    psel  = (int'(page) < PAGES) ? int'(page) : 0;
    rdata = cells[(bsel*PAGES+psel)*W +: W];
  end

endmodule

// File: rtl/nand_prog_guard.sv
module nand_prog_guard
  import npg_pkg::*;
#(
  parameter int BLOCKS      = 6,
  parameter int PAGES       = 6,
  parameter int PAGE_BYTES  = 8,
  parameter int SPARE_BYTES = 2,
  parameter int NOP_MAX     = 4,
  localparam int BLK_W      = $clog2(BLOCKS),
  localparam int PG_W       = $clog2(PAGES),
  localparam int PTR_W      = $clog2(PAGES + 1),
  localparam int CNT_W      = $clog2(NOP_MAX + 1),
  localparam int PAGE_BITS  = PAGE_BYTES * 8,
  localparam int SPARE_BITS = SPARE_BYTES * 8,
  localparam int ENT_W      = PAGE_BITS + SPARE_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [1:0]            cmd_op,
  input  logic [BLK_W-1:0]      cmd_blk,
  input  logic [PG_W-1:0]       cmd_page,
  input  logic [PAGE_BITS-1:0]  cmd_data,
  input  logic [SPARE_BITS-1:0] cmd_spare,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_err,
  output logic [PAGE_BITS-1:0]  rsp_data,
  output logic [SPARE_BITS-1:0] rsp_spare
);

  op_e              op;
  err_e             verdict;
  logic [PTR_W-1:0] cur_nxt;
  logic [CNT_W-1:0] cur_cnt;
  logic [ENT_W-1:0] rd_word;
  logic             accept;
  logic             clean;
  logic             prog_en;
  logic             erase_en;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign clean     = (verdict == ERR_NONE);
  assign prog_en   = accept && clean && (op == OP_PROG);
  assign erase_en  = accept && clean && (op == OP_ERASE);

  npg_rules #(
    .BLOCKS(BLOCKS), .PAGES(PAGES), .NOP_MAX(NOP_MAX),
    .BLK_W(BLK_W), .PG_W(PG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_rules (
    .op   (op),
    .blk  (cmd_blk),
    .page (cmd_page),
    .nxt  (cur_nxt),
    .cnt  (cur_cnt),
    .err  (verdict)
  );

  npg_book #(
    .BLOCKS(BLOCKS), .PAGES(PAGES),
    .BLK_W(BLK_W), .PG_W(PG_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_book (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk      (cmd_blk),
    .page     (cmd_page),
    .prog_en  (prog_en),
    .erase_en (erase_en),
    .nxt      (cur_nxt),
    .cnt      (cur_cnt)
  );

  npg_array #(
    .BLOCKS(BLOCKS), .PAGES(PAGES),
    .BLK_W(BLK_W), .PG_W(PG_W), .W(ENT_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk      (cmd_blk),
    .page     (cmd_page),
    .prog_en  (prog_en),
    .erase_en (erase_en),
    .wdata    ({cmd_spare, cmd_data}),
    .rdata    (rd_word)
  );

  // single response register: loads on accept, empties on hand-over
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 2'd0;
      rsp_data  <= '0;
      rsp_spare <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= verdict;
      if (clean && op == OP_READ) begin
        {rsp_spare, rsp_data} <= rd_word;
      end else begin
        {rsp_spare, rsp_data} <= '0;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/npg_checks.sv
module npg_checks #(
  parameter int BLOCKS     = 6,
  parameter int BLK_W      = 3,
  parameter int PAGE_BITS  = 64,
  parameter int SPARE_BITS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [1:0]            cmd_op,
  input logic [BLK_W-1:0]      cmd_blk,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [1:0]            rsp_err,
  input logic [PAGE_BITS-1:0]  rsp_data,
  input logic [SPARE_BITS-1:0] rsp_spare
);

  AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid); // R2

  AST_STALL_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready); // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) && $stable(rsp_data) && $stable(rsp_spare))); // R3

  AST_ORDER_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != 2'd1) |=> (rsp_err != 2'd1)); // R6

  AST_NOP_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != 2'd1) |=> (rsp_err != 2'd2)); // R7

  AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (int'(cmd_blk) >= BLOCKS || cmd_op == 2'd3)) |=> (rsp_err == 2'd3)); // R8

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'd0) |-> (rsp_data == '0 && rsp_spare == '0)); // R10

endmodule

bind nand_prog_guard npg_checks #(
  .BLOCKS(BLOCKS), .BLK_W(BLK_W), .PAGE_BITS(PAGE_BITS), .SPARE_BITS(SPARE_BITS)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_blk   (cmd_blk),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .rsp_spare (rsp_spare)
);

// File: tb/nand_prog_guard_test.sv
module nand_prog_guard_test;

  localparam int NB   = 6;
  localparam int NP   = 6;
  localparam int NOPM = 4;
  localparam int BW   = 3;
  localparam int PW   = 3;
  localparam int PB   = 64;
  localparam int SB   = 16;
  localparam int W    = PB + SB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [BW-1:0] cmd_blk = '0;
  logic [PW-1:0] cmd_page = '0;
  logic [PB-1:0] cmd_data = '0;
  logic [SB-1:0] cmd_spare = '0;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [1:0]    rsp_err;
  logic [PB-1:0] rsp_data;
  logic [SB-1:0] rsp_spare;

  logic          bp_mode = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;
  int            checks = 0;
  int            failures = 0;
  int            cyc = 0;

  assign rsp_ready = !bp_mode || lfsr[0];

  always #10 clk = ~clk;

  nand_prog_guard #(
    .BLOCKS(NB), .PAGES(NP), .PAGE_BYTES(PB/8), .SPARE_BYTES(SB/8), .NOP_MAX(NOPM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_data(cmd_data),
    .cmd_spare(cmd_spare), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .rsp_spare(rsp_spare)
  );

  // ---------------- behavioural reference ----------------
  logic [W-1:0]   rmem [NB*NP];
  int             rcnt [NB*NP];
  int             rnxt [NB];
  logic           exp_valid;
  logic           exp_held;
  logic [W+1:0]   exp_rsp;
  string          exp_tag;
  logic           first_cmd;
  logic [W+1:0]   rq [$];

  task automatic model_cmd();
    int b = int'(cmd_blk);
    int p = int'(cmd_page);
    int o = int'(cmd_op);
    exp_rsp = '0;
    if (o == 3 || b >= NB || (o != 2 && p >= NP)) begin
      exp_rsp[W+1:W] = 2'd3;
      exp_tag = "R8/R10";
    end else if (o == 0) begin
      exp_rsp[W-1:0] = rmem[b*NP+p];
      exp_tag = first_cmd ? "R1" : "R4";
    end else if (o == 1) begin
      if (p > rnxt[b]) begin
        exp_rsp[W+1:W] = 2'd1;
        exp_tag = "R6/R10";
      end else if (p < rnxt[b] && rcnt[b*NP+p] >= NOPM) begin
        exp_rsp[W+1:W] = 2'd2;
        exp_tag = "R7/R10";
      end else begin
        exp_tag = (p == rnxt[b]) ? "R5" : "R7";
        rmem[b*NP+p] = rmem[b*NP+p] & {cmd_spare, cmd_data};
        rcnt[b*NP+p]++;
        if (p == rnxt[b]) rnxt[b]++;
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        rmem[b*NP+i] = '1;
        rcnt[b*NP+i] = 0;
      end
      rnxt[b] = 0;
      exp_tag = "R9";
    end
    first_cmd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < NB*NP; i++) begin
        rmem[i] = '1;
        rcnt[i] = 0;
      end
      for (int i = 0; i < NB; i++) rnxt[i] = 0;
      exp_valid = 1'b0;
      exp_held  = 1'b0;
      exp_rsp   = '0;
      exp_tag   = "R1";
      first_cmd = 1'b1;
    end else if (cmd_valid && (!exp_valid || rsp_ready)) begin
      model_cmd();
      exp_valid = 1'b1;
      exp_held  = 1'b0;
    end else if (exp_valid && rsp_ready) begin
      exp_valid = 1'b0;
    end else if (exp_valid) begin
      exp_held = 1'b1;
    end
  end

  task automatic check(string tag, logic [W+1:0] act, logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge; also log handed-over responses
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #2;
    if (rst_n) begin
      check("R2 cmd_ready", (W+2)'(cmd_ready), (W+2)'(!exp_valid || rsp_ready));
      check("R2 rsp_valid", (W+2)'(rsp_valid), (W+2)'(exp_valid));
      if (exp_valid)
        check(exp_held ? "R3" : exp_tag, {rsp_err, rsp_spare, rsp_data}, exp_rsp);
      if (rsp_valid && rsp_ready) rq.push_back({rsp_err, rsp_spare, rsp_data});
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int op, int blk, int page, logic [PB-1:0] d, logic [SB-1:0] s);
    @(negedge clk);
    cmd_op    = 2'(op);
    cmd_blk   = BW'(blk);
    cmd_page  = PW'(page);
    cmd_data  = d;
    cmd_spare = s;
    cmd_valid = 1'b1;
    #2;
    while (!cmd_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic expect_rsp(string tag, logic [1:0] e, logic [W-1:0] v);
    logic [W+1:0] got;
    wait (rq.size() > 0);
    got = rq.pop_front();
    check(tag, got, {e, v});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  localparam logic [PB-1:0] DA = 64'h0123_4567_89AB_CDEF;
  localparam logic [SB-1:0] SA = 16'hBEEF;
  localparam logic [PB-1:0] DB = 64'hFF00_F0F0_FF00_0FF0;
  localparam logic [SB-1:0] SBv = 16'h0FF0;
  localparam logic [PB-1:0] DC = 64'hFFFF_0000_FFFF_7777;
  localparam logic [SB-1:0] SC = 16'hF0FF;
  localparam logic [PB-1:0] DE = 64'h5555_AAAA_3333_CCCC;
  localparam logic [SB-1:0] SE = 16'h1234;

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 ready after reset", (W+2)'(cmd_ready), (W+2)'(1));
    check("R1 valid after reset", (W+2)'(rsp_valid), (W+2)'(0));

    send(0, 0, 0, '0, '0);            expect_rsp("R1 erased read", 2'd0, '1);
    send(1, 0, 0, DA, SA);            expect_rsp("R5 first program", 2'd0, '0);
    send(0, 0, 0, '0, '0);            expect_rsp("R5 readback", 2'd0, {SA, DA});
    send(1, 0, 0, DB, SBv);           expect_rsp("R7 partial ok", 2'd0, '0);
    send(0, 0, 0, '0, '0);            expect_rsp("R5 AND merge", 2'd0, {SA & SBv, DA & DB});
    send(1, 0, 2, '0, '0);            expect_rsp("R6 skip ahead", 2'd1, '0);
    send(0, 0, 2, '0, '0);            expect_rsp("R6 no effect", 2'd0, '1);
    send(1, 0, 0, DC, SC);            expect_rsp("R7 third", 2'd0, '0);
    send(1, 0, 0, DC, SC);            expect_rsp("R7 fourth", 2'd0, '0);
    send(1, 0, 0, '0, '0);            expect_rsp("R7 limit hit", 2'd2, '0);
    send(0, 0, 0, '0, '0);            expect_rsp("R7 unchanged", 2'd0, {SA & SBv & SC, DA & DB & DC});
    send(1, 0, 1, DE, SE);            expect_rsp("R5 next page", 2'd0, '0);
    send(1, 1, 0, DE, SE);            expect_rsp("R5 other block", 2'd0, '0);
    send(0, 6, 0, '0, '0);            expect_rsp("R8 block range", 2'd3, '0);
    send(1, 0, 7, '0, '0);            expect_rsp("R8 page range", 2'd3, '0);
    send(3, 0, 0, '0, '0);            expect_rsp("R8 bad opcode", 2'd3, '0);
    send(2, 7, 0, '0, '0);            expect_rsp("R8 erase range", 2'd3, '0);
    send(2, 2, 7, '0, '0);            expect_rsp("R8 erase page ignored", 2'd0, '0);
    send(2, 0, 0, '0, '0);            expect_rsp("R9 erase", 2'd0, '0);
    send(0, 0, 0, '0, '0);            expect_rsp("R9 page ones", 2'd0, '1);
    send(0, 0, 1, '0, '0);            expect_rsp("R9 second page ones", 2'd0, '1);
    send(0, 1, 0, '0, '0);            expect_rsp("R9 other block kept", 2'd0, {SE, DE});
    send(1, 0, 1, '0, '0);            expect_rsp("R9 pointer reset", 2'd1, '0);
    send(1, 0, 0, DA, SA);            expect_rsp("R9 program after erase", 2'd0, '0);

    // back to back: one accept per cycle while the response drains
    send(0, 0, 0, '0, '0);
    t0 = cyc;
    send(0, 1, 0, '0, '0);
    send(0, 2, 0, '0, '0);
    send(0, 3, 0, '0, '0);
    check("R2 back-to-back cycles", (W+2)'(cyc - t0), (W+2)'(3));
    repeat (3) @(negedge clk);
    rq.delete();

    // random traffic under back-pressure, judged by the per-cycle model
    @(negedge clk);
    bp_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int o = $urandom % 8;
      send((o < 4) ? 1 : (o == 7) ? 2 : (o == 6) ? 3 : 0, $urandom % 7, $urandom % 7,
           {$urandom, $urandom}, 16'($urandom));
    end
    @(negedge clk);
    bp_mode = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule